// File: doc/BRIEF.md
# Serial Word Transmitter with Framing Pulse

This block takes parallel words over a valid/ready input and sends each one on a single serial data line, most significant bit first. Each bit takes one period of the block clock, which serves as the serial bit clock. A companion sync line carries one pulse of one clock period for each word. The pulse marks where the word sits in the bit stream.

The pulse position is chosen per word. It can fall in a padding period just before the first data bit, in a padding period just after the last data bit, or in the same period as the first data bit. The pulse polarity is set by a plain control pin. The word length runs from 8 to 32 bits and is taken with each word.

The input follows valid/ready rules. The producer holds `in_valid`, `in_data`, `word_len` and `sync_pos` steady until a cycle in which `in_ready` is also high, and the word is taken on that edge. While a frame is being sent, `in_ready` stays low, which back-pressures the producer. It rises only in the last bit period of the frame, so a word that is waiting starts on the very next period and consecutive frames leave no gap. `sync_low` is a control pin and not part of the stream. It should change only while the line is idle.

Top module: `ser_word_sync`

## Requirements
- R1: A taken word of length `word_len` (8 to 32) is sent MSB first. Bit `word_len-1` of `in_data` goes out first and bit 0 goes out last. Bits above `word_len-1` are ignored.
- R2: With `sync_pos` = 00 (early), the frame has `word_len+1` periods. Period 0 is padding: data is low and the sync pulse is active. The data bits follow in periods 1 to `word_len`.
- R3: With `sync_pos` = 01 (late), the frame has `word_len+1` periods. The data bits fill periods 0 to `word_len-1`. Period `word_len` is padding: data is low and the sync pulse is active.
- R4: With `sync_pos` = 10 or 11 (coincident), the frame has exactly `word_len` periods and the sync pulse is active in period 0, together with the first data bit.
- R5: With `sync_low` = 0, sync is active high. With `sync_low` = 1, sync is active low. In every period where no pulse is active, `ser_sync` sits at the inactive level, `sync_low`.
- R6: Each frame has exactly one sync pulse, and it lasts exactly one clock period.
- R7: When no frame is in progress, `ser_data` is low, `ser_sync` is inactive and `in_ready` is high.
- R8: During a frame, `in_ready` is low in every period except the last, where it is high. A word offered while `in_ready` is low is not taken. A word taken on an edge has its period 0 on the outputs in the cycle right after that edge, so back-to-back frames have no gap.
- R9: After reset, no frame is in progress: `in_ready` is high, `ser_data` is low and `ser_sync` equals `sync_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can take a word on this edge |
| in_data | input | MAX_W | Word to send, right-aligned |
| word_len | input | CW | Number of bits to send, 8 to MAX_W |
| sync_pos | input | 2 | Pulse position: 00 early, 01 late, 1x coincident |
| sync_low | input | 1 | 1 selects an active-low sync pulse |
| ser_data | output | 1 | Serial data, MSB first |
| ser_sync | output | 1 | Framing pulse |

## Verification
The checker assumes two things about the inputs. Any offered word carries a `word_len` from 8 to 32. `sync_low` does not change while a frame is in progress, because the inactive level and the pulse level are judged against the live pin.

The bench keeps to both assumptions. It sweeps every legal length against all four position codes and both polarities. It changes `sync_low` only when the line is idle, and it raises `in_valid` early during a frame to test that the word is held back until the frame ends.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    SP_EARLY = 2'b00,
    SP_LATE  = 2'b01,
    SP_COIN  = 2'b10
  } sync_pos_e;

  // Early and late positions add one padding period; 1x codes do not.
  function automatic logic pos_has_pad(input logic [1:0] pos);
    return ~pos[1];
  endfunction
endpackage

// File: rtl/ser_frame_ctl.sv
module ser_frame_ctl
  import ser_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] word_len,
  input  logic [1:0]    sync_pos,
  output logic          in_ready,
  output logic          accept,
  output logic          busy,
  output logic [CW-1:0] slot,
  output logic [CW-1:0] last,
  output logic [1:0]    pos_q,
  output logic          data_slot,
  output logic          shift_en
);
  logic          busy_q;
  logic [CW-1:0] slot_q, last_q;
  logic [1:0]    pos_r;
  logic          at_end;
  logic [CW-1:0] last_next;

  assign at_end    = (slot_q == last_q);
  assign in_ready  = ~busy_q | at_end;
  assign accept    = in_valid & in_ready;
  assign last_next = word_len - CW'(1) + CW'(pos_has_pad(sync_pos));

  always_comb begin
    data_slot = busy_q;
    if (pos_r == SP_EARLY && slot_q == '0) data_slot = 1'b0;
    if (pos_r == SP_LATE && at_end)        data_slot = 1'b0;
  end

  assign shift_en = data_slot & ~at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      last_q <= '0;
      pos_r  <= SP_EARLY;
    end else if (accept) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      last_q <= last_next;
      pos_r  <= sync_pos;
    end else if (busy_q) begin
      if (at_end) begin
        busy_q <= 1'b0;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + CW'(1);
      end
    end
  end

  assign busy  = busy_q;
  assign slot  = slot_q;
  assign last  = last_q;
  assign pos_q = pos_r;
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int MAX_W = 32,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAX_W-1:0] din,
  input  logic [CW-1:0]    word_len,
  input  logic             shift,
  output logic             msb
);
  logic [MAX_W-1:0] sr_q;
  logic [CW-1:0]    align;

  // Left-align the word so its first bit sits in the top position.
  assign align = CW'(MAX_W) - word_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= din << align;
    else if (shift) sr_q <= {sr_q[MAX_W-2:0], 1'b0};
  end

  assign msb = sr_q[MAX_W-1];
endmodule

// File: rtl/ser_sync_gen.sv
module ser_sync_gen
  import ser_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          busy,
  input  logic [CW-1:0] slot,
  input  logic [CW-1:0] last,
  input  logic [1:0]    pos_q,
  input  logic          data_slot,
  input  logic          msb,
  input  logic          sync_low,
  output logic          sync_act,
  output logic          ser_data,
  output logic          ser_sync
);
  always_comb begin
    sync_act = 1'b0;
    if (busy) begin
      if (pos_q == SP_LATE) sync_act = (slot == last);
      else                  sync_act = (slot == '0);
    end
  end

  assign ser_data = data_slot & msb;
  assign ser_sync = sync_act ^ sync_low;
endmodule

// File: rtl/ser_word_sync.sv
module ser_word_sync #(
  parameter int MAX_W = 32,
  parameter int CW    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MAX_W-1:0] in_data,
  input  logic [CW-1:0]    word_len,
  input  logic [1:0]       sync_pos,
  input  logic             sync_low,
  output logic             ser_data,
  output logic             ser_sync
);
  logic          accept, busy, data_slot, shift_en, msb, sync_act;
  logic [CW-1:0] slot, last;
  logic [1:0]    pos_q;

  ser_frame_ctl #(.MAX_W(MAX_W), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_len(word_len),
    .sync_pos(sync_pos), .in_ready(in_ready), .accept(accept), .busy(busy),
    .slot(slot), .last(last), .pos_q(pos_q), .data_slot(data_slot),
    .shift_en(shift_en)
  );

  ser_shifter #(.MAX_W(MAX_W), .CW(CW)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(in_data),
    .word_len(word_len), .shift(shift_en), .msb(msb)
  );

  ser_sync_gen #(.CW(CW)) u_sync (
    .busy(busy), .slot(slot), .last(last), .pos_q(pos_q),
    .data_slot(data_slot), .msb(msb), .sync_low(sync_low),
    .sync_act(sync_act), .ser_data(ser_data), .ser_sync(ser_sync)
  );
endmodule

// File: rtl/ser_word_sync_chk.sv
module ser_word_sync_chk #(
  parameter int MAX_W = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [CW-1:0] word_len,
  input logic          sync_low,
  input logic          ser_data,
  input logic          ser_sync,
  input logic          busy,
  input logic [CW-1:0] slot,
  input logic [1:0]    pos_q
);
  logic pulse;
  assign pulse = ser_sync ^ sync_low;

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (word_len >= CW'(8) && word_len <= CW'(MAX_W))); // R1
  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !pos_q[1] && pulse |-> !ser_data); // R2
  AST_COIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pos_q[1] && pulse |-> slot == '0); // R4
  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_sync == sync_low); // R5
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse && !in_ready |=> !pulse); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_data && in_ready); // R7
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && slot == '0); // R8
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_ready |=> busy && slot != '0); // R8
endmodule

bind ser_word_sync ser_word_sync_chk #(.MAX_W(MAX_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .word_len(word_len), .sync_low(sync_low), .ser_data(ser_data),
  .ser_sync(ser_sync), .busy(busy), .slot(slot), .pos_q(pos_q)
);

// File: tb/ser_word_sync_tb.sv
module ser_word_sync_tb;
  localparam int MAX_W = 32;
  localparam int CW    = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [MAX_W-1:0] in_data = '0;
  logic [CW-1:0]    word_len = CW'(8);
  logic [1:0]       sync_pos = 2'b00;
  logic             sync_low = 1'b0;
  logic             ser_data, ser_sync;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_word_sync #(.MAX_W(MAX_W), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .word_len(word_len), .sync_pos(sync_pos),
    .sync_low(sync_low), .ser_data(ser_data), .ser_sync(ser_sync)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected data bit in period k of a frame.
  function automatic int exp_bit(input logic [31:0] w, input int len, input int pos, input int k);
    int idx;
    if (pos == 0) begin
      if (k == 0) return 0;
      idx = len - k;
    end else begin
      if (k >= len) return 0;
      idx = len - 1 - k;
    end
    return int'(w[idx]);
  endfunction

  function automatic int exp_act(input int len, input int pos, input int k);
    if (pos == 1) return (k == len) ? 1 : 0;
    return (k == 0) ? 1 : 0;
  endfunction

  // Offer a word; returns with period 0 of that frame visible.
  task automatic offer(input logic [31:0] w, input int len, input int pos);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; word_len = CW'(len); sync_pos = 2'(pos);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Observe one frame from period 0. When nxt is set, a second word is
  // offered from period 1 on and must start right after this frame.
  task automatic observe(input logic [31:0] w, input int len, input int pos, input int pol,
                         input bit nxt, input logic [31:0] nw, input int nlen, input int npos);
    int flen, bad_d, bad_s, bad_r, pulses;
    flen = len + ((pos < 2) ? 1 : 0);
    bad_d = 0; bad_s = 0; bad_r = 0; pulses = 0;
    for (int k = 0; k < flen; k++) begin
      if (int'(ser_data) != exp_bit(w, len, pos, k)) bad_d++;
      if (int'(ser_sync) != (exp_act(len, pos, k) ^ pol)) bad_s++;
      if ((ser_sync ^ pol[0]) == 1'b1) pulses++;
      if (int'(in_ready) != ((k == flen - 1) ? 1 : 0)) bad_r++;
      if (nxt && k == 1) begin
        in_valid = 1'b1; in_data = nw; word_len = CW'(nlen); sync_pos = 2'(npos);
      end
      @(negedge clk);
    end
    if (nxt) in_valid = 1'b0;
    case (pos)
      0: chk("R2", "early data/pad mismatches", bad_d, 0);
      1: chk("R3", "late data/pad mismatches", bad_d, 0);
      default: chk("R4", "coincident data mismatches", bad_d, 0);
    endcase
    chk("R1", "msb-first bit errors", bad_d, 0);
    chk("R5", "sync level mismatches", bad_s, 0);
    chk("R6", "pulses per frame", pulses, 1);
    chk("R8", "ready pattern mismatches", bad_r, 0);
  endtask

  initial begin
    logic [31:0] w;
    #1;
    chk("R9", "ready in reset", int'(in_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready after reset", int'(in_ready), 1);
    chk("R9", "data after reset", int'(ser_data), 0);
    chk("R9", "sync after reset", int'(ser_sync), 0);

    for (int pol = 0; pol < 2; pol++) begin
      sync_low = pol[0];
      @(negedge clk);
      for (int pos = 0; pos < 4; pos++) begin
        for (int len = 8; len <= MAX_W; len++) begin
          w = 32'hA5C3_96F1 ^ (32'(len) * 32'h0101_0107) ^ (32'(pos) << 20);
          offer(w, len, pos);
          observe(w, len, pos, pol, 1'b0, '0, 8, 0);
          chk("R7", "idle data", int'(ser_data), 0);
          chk("R7", "idle sync", int'(ser_sync), pol);
          chk("R7", "idle ready", int'(in_ready), 1);
        end
      end
    end

    // Back-to-back chains across positions; next word held while ready low.
    sync_low = 1'b0;
    @(negedge clk);
    offer(32'hFFFF_FFFF, 32, 1);
    observe(32'hFFFF_FFFF, 32, 1, 0, 1'b1, 32'h0000_00B7, 8, 0);
    observe(32'h0000_00B7, 8, 0, 0, 1'b1, 32'h0001_2345, 17, 2);
    observe(32'h0001_2345, 17, 2, 0, 1'b1, 32'hDEAD_BEEF, 9, 3);
    observe(32'hDEAD_BEEF & 32'h1FF, 9, 3, 0, 1'b0, '0, 8, 0);
    chk("R7", "idle after chain", int'(ser_data), 0);

    sync_low = 1'b1;
    @(negedge clk);
    offer(32'h8000_0001, 32, 2);
    observe(32'h8000_0001, 32, 2, 1, 1'b1, 32'h55, 8, 1);
    observe(32'h55, 8, 1, 1, 1'b0, '0, 8, 0);
    chk("R5", "idle sync active-low", int'(ser_sync), 1);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule